// File: doc/BRIEF.md
# Byte-Level I2C Master Command Front End

This block is the software-facing half of an I2C master. Software loads a slave address with its direction bit, a data byte and a configuration word through a small register port. It then writes a command word holding start, run and stop bits. The block turns that command into an ordered sequence of at most three requests on an abstract byte-level bus interface: open the bus, move one byte, release the bus. Each request is held until the bus side answers with a one-cycle done pulse.

The block keeps busy, error and arbitration-lost flags. It raises a maskable interrupt each time a byte has moved. Waveform generation on SCL and SDA lives behind the bus interface and is not part of this block. The clock-period register is only stored and read back.

Top module: `i2cm_ctrl`

## Requirements
- R1: Register offsets on `reg_addr` are: 0 slave address (8 bits: [7:1] 7-bit address, [0] direction, 1 = read), 1 command on write and status on read, 2 data (8 bits), 3 clock period (8 bits), 4 interrupt enable (bit 0), 5 raw interrupt, 6 masked interrupt (read only), 7 configuration. Configuration keeps only the bits in mask 0x31.
- R2: A command write is ignored, and no bus request follows, unless configuration bit 4 (master enable) is set. A command write is also ignored while an earlier command is still being carried out.
- R3: A start request (`bus_op` = 0) is issued only when command bit 1 is set and the busy flag is clear. Otherwise the start phase is skipped.
- R4: When the start request completes, `bus_fail` = 1 sets arbitration-lost and leaves busy unchanged. `bus_fail` = 0 clears arbitration-lost and sets busy.
- R5: With command bit 0 (run) set, if `bus_active` is low or busy is clear, the error flag is set and no byte request is made. Otherwise the error flag is cleared and one byte request (`bus_op` = 1) is made. In the read direction the data register is loaded from `bus_rdata` at done. In the write direction the data register is presented on `bus_wdata`. Without run, the error flag is unchanged.
- R6: With command bit 2 (stop) set, a release request (`bus_op` = 2) is made after the start and run phases. Busy clears when it completes.
- R7: The status read returns busy in bit 0, error in bit 1, arbitration-lost in bit 4 and a constant 1 in bit 5 (idle). All other bits read 0.
- R8: Raw interrupt bit 0 is set when a byte request completes. Writing 1 to bit 0 of offset 5 clears it, and writing 0 leaves it. `irq` and the offset-6 read equal raw AND enable.
- R9: Reset sets the period register to 1 and every other register and flag to 0. `bus_abort` is high while `rst_n` is low and busy is set, so an open bus is released.
- R10: `bus_req` stays high with `bus_op` unchanged from the cycle it rises until the cycle of `bus_done`. It falls in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt, raw AND enable |
| bus_req | output | 1 | Bus request, held until done |
| bus_op | output | 2 | Request kind: 0 start, 1 byte, 2 release |
| bus_rd | output | 1 | Direction of the transfer, 1 = read |
| bus_addr | output | 7 | 7-bit slave address |
| bus_wdata | output | 8 | Byte to send |
| bus_done | input | 1 | One-cycle completion of the current request |
| bus_fail | input | 1 | Start failed (arbitration lost), valid with done |
| bus_rdata | input | 8 | Received byte, valid with done |
| bus_active | input | 1 | Bus side has a transfer open |
| bus_abort | output | 1 | Release the bus because of reset during a transfer |

## Verification
The assertions assume that the bus side raises `bus_done` only while `bus_req` is high, for a single cycle. They also assume that `bus_fail` and `bus_rdata` are valid in that same cycle. One of the assertions checks the first assumption. The bench's bus model answers every request exactly two cycles after it sees it and drops done at the next falling edge, so it never answers twice. The model raises `bus_active` only after a successful start and lowers it only on release. It is also lowered by hand after a reset during a transfer, which keeps the bus-side state consistent with what a real bus would report.

// File: rtl/i2cm_pkg.sv
// Shared types and constants of the I2C master command front end.
// Assumes an 8-bit register port with 3-bit offsets.
package i2cm_pkg;
    localparam int REG_AW = 3;

    // Register offsets
    localparam logic [REG_AW-1:0] OFS_SLV   = 3'd0;
    localparam logic [REG_AW-1:0] OFS_CMD   = 3'd1;
    localparam logic [REG_AW-1:0] OFS_DATA  = 3'd2;
    localparam logic [REG_AW-1:0] OFS_PER   = 3'd3;
    localparam logic [REG_AW-1:0] OFS_IEN   = 3'd4;
    localparam logic [REG_AW-1:0] OFS_IRAW  = 3'd5;
    localparam logic [REG_AW-1:0] OFS_IMSK  = 3'd6;
    localparam logic [REG_AW-1:0] OFS_CFG   = 3'd7;

    // Command bits, configuration enable bit, status bits
    localparam int CMD_RUN   = 0;
    localparam int CMD_START = 1;
    localparam int CMD_STOP  = 2;
    localparam int CFG_EN    = 4;
    localparam int ST_BUSY   = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_ARB    = 4;
    localparam int ST_IDLE   = 5;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_XFER  = 2'd1,
        OP_END   = 2'd2
    } bus_op_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_START, SQ_RUN, SQ_XFER, SQ_STOP, SQ_END
    } seq_state_e;
endpackage

// File: rtl/i2cm_regs.sv
// Register file of the I2C master front end: slave address, data,
// period, configuration, interrupt enable and raw interrupt, plus the
// combinational read mux. Assumes rx_load and raw_set are single-cycle
// strobes from the sequencer.
module i2cm_regs
    import i2cm_pkg::*;
#(
    parameter int                DW         = 8,
    parameter logic [DW-1:0]     CFG_MASK   = 8'h31,
    parameter logic [DW-1:0]     PERIOD_RST = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              rx_load,
    input  logic [DW-1:0]     rx_data,
    input  logic              raw_set,
    input  logic [DW-1:0]     status,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     slv,
    output logic [DW-1:0]     data,
    output logic              cfg_en,
    output logic              raw,
    output logic              irq
);
    logic [DW-1:0] period;
    logic [DW-1:0] cfg;
    logic          ien;
    logic          raw_clr;

    assign raw_clr = we && (addr == OFS_IRAW) && wdata[0];
    assign cfg_en  = cfg[CFG_EN];
    assign irq     = raw & ien;

    // Store software-written registers; the received byte overrides data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slv    <= '0;
            data   <= '0;
            period <= PERIOD_RST;
            cfg    <= '0;
            ien    <= 1'b0;
        end else begin
            if (we) begin
                unique case (addr)
                    OFS_SLV: slv    <= wdata;
                    OFS_PER: period <= wdata;
                    OFS_IEN: ien    <= wdata[0];
                    OFS_CFG: cfg    <= wdata & CFG_MASK;
                    default: ;
                endcase
            end
            if (rx_load)
                data <= rx_data;
            else if (we && addr == OFS_DATA)
                data <= wdata;
        end
    end

    // Raw interrupt: set by a finished byte, cleared by a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= 1'b0;
        else        raw <= raw_set | (raw & ~raw_clr);
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_SLV:  rdata = slv;
            OFS_CMD:  rdata = status;
            OFS_DATA: rdata = data;
            OFS_PER:  rdata = period;
            OFS_IEN:  rdata[0] = ien;
            OFS_IRAW: rdata[0] = raw;
            OFS_IMSK: rdata[0] = raw & ien;
            OFS_CFG:  rdata = cfg;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2cm_seq.sv
// Command sequencer: runs the start, byte and release phases of one
// accepted command in that order, holding each bus request until done.
// Owns the busy, error and arbitration-lost flags. Assumes bus_done is
// a one-cycle pulse given only while bus_req is high.
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = DW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_go,
    input  logic [DW-1:0] cmd,
    input  logic [DW-1:0] slv,
    input  logic [DW-1:0] data,
    input  logic          bus_done,
    input  logic          bus_fail,
    input  logic          bus_active,
    output logic          idle,
    output logic          busy,
    output logic          err,
    output logic          arb,
    output logic          raw_set,
    output logic          rx_load,
    output logic          bus_req,
    output logic [1:0]    bus_op,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata
);
    seq_state_e state;
    logic       run_q;
    logic       stop_q;

    // Phase sequencing and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            run_q  <= 1'b0;
            stop_q <= 1'b0;
            busy   <= 1'b0;
            err    <= 1'b0;
            arb    <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: if (cmd_go) begin
                    run_q  <= cmd[CMD_RUN];
                    stop_q <= cmd[CMD_STOP];
                    state  <= (cmd[CMD_START] && !busy) ? SQ_START : SQ_RUN;
                end
                SQ_START: if (bus_done) begin
                    if (bus_fail) arb <= 1'b1;
                    else begin
                        arb  <= 1'b0;
                        busy <= 1'b1;
                    end
                    state <= SQ_RUN;
                end
                SQ_RUN: begin
                    if (!run_q) state <= SQ_STOP;
                    else if (!bus_active || !busy) begin
                        err   <= 1'b1;
                        state <= SQ_STOP;
                    end else begin
                        err   <= 1'b0;
                        state <= SQ_XFER;
                    end
                end
                SQ_XFER: if (bus_done) state <= SQ_STOP;
                SQ_STOP: state <= stop_q ? SQ_END : SQ_IDLE;
                SQ_END: if (bus_done) begin
                    busy  <= 1'b0;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Bus request outputs decoded from the phase.
    always_comb begin
        bus_req = (state == SQ_START) || (state == SQ_XFER) || (state == SQ_END);
        unique case (state)
            SQ_XFER: bus_op = OP_XFER;
            SQ_END:  bus_op = OP_END;
            default: bus_op = OP_START;
        endcase
    end

    assign idle      = (state == SQ_IDLE);
    assign bus_rd    = slv[0];
    assign bus_addr  = slv[DW-1:1];
    assign bus_wdata = data;
    assign raw_set   = (state == SQ_XFER) && bus_done;
    assign rx_load   = raw_set && slv[0];
endmodule

// File: rtl/i2cm_ctrl.sv
// Top of the I2C master command front end: joins the register file and
// the sequencer, gates command writes and builds the status word.
// Assumes a bus side that answers each request with one done pulse.
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = DW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic              bus_rd,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_done,
    input  logic              bus_fail,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_active,
    output logic              bus_abort
);
    logic          busy, err, arb, idle, cfg_en, irq_raw;
    logic          raw_set, rx_load, cmd_go;
    logic [DW-1:0] slv, data, status;

    assign cmd_go = reg_we && (reg_addr == OFS_CMD) && cfg_en && idle;

    // Status word assembled from the sequencer flags.
    always_comb begin
        status          = '0;
        status[ST_BUSY] = busy;
        status[ST_ERR]  = err;
        status[ST_ARB]  = arb;
        status[ST_IDLE] = 1'b1;
    end

    assign bus_abort = !rst_n && busy;

    i2cm_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rx_load (rx_load),
        .rx_data (bus_rdata),
        .raw_set (raw_set),
        .status  (status),
        .rdata   (reg_rdata),
        .slv     (slv),
        .data    (data),
        .cfg_en  (cfg_en),
        .raw     (irq_raw),
        .irq     (irq)
    );

    i2cm_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_go     (cmd_go),
        .cmd        (reg_wdata),
        .slv        (slv),
        .data       (data),
        .bus_done   (bus_done),
        .bus_fail   (bus_fail),
        .bus_active (bus_active),
        .idle       (idle),
        .busy       (busy),
        .err        (err),
        .arb        (arb),
        .raw_set    (raw_set),
        .rx_load    (rx_load),
        .bus_req    (bus_req),
        .bus_op     (bus_op),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata)
    );
endmodule

// File: rtl/i2cm_ctrl_chk.sv
// Protocol and flag checker for i2cm_ctrl, attached by bind.
// Assumes the bus side gives done only while a request is pending.
module i2cm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic [1:0] bus_op,
    input logic       bus_done,
    input logic       busy,
    input logic       raw
);
    // R10: request held with a stable kind until done
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_op));

    // R10: done only answers a pending request
    a_r10_done_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |-> bus_req);

    // R3: no start request while busy
    a_r3_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_op == 2'd0 |-> !busy);

    // R4: busy rises only after a completed start
    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_req && bus_done && bus_op == 2'd0 && !$isunknown(bus_op)));

    // R6: busy falls only after a completed release
    a_r6_busy_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(rst_n) |-> $past(bus_req && bus_done && bus_op == 2'd2));

    // R8: raw interrupt rises only after a completed byte
    a_r8_raw_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(bus_req && bus_done && bus_op == 2'd1));
endmodule

bind i2cm_ctrl i2cm_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_op   (bus_op),
    .bus_done (bus_done),
    .busy     (busy),
    .raw      (irq_raw)
);

// File: tb/tb_i2cm_ctrl.sv
module tb_i2cm_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, bus_req, bus_rd, bus_abort;
    logic [1:0] bus_op;
    logic [6:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_done = 1'b0;
    logic       bus_fail = 1'b0;
    logic [7:0] bus_rdata = '0;
    logic       bus_active = 1'b0;

    int n_chk = 0, n_fail = 0;
    int n_start = 0, n_end = 0;
    logic       tb_fail = 1'b0;
    logic [7:0] last_tx = '0;
    int lat = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    i2cm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_op(bus_op), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done),
        .bus_fail(bus_fail), .bus_rdata(bus_rdata),
        .bus_active(bus_active), .bus_abort(bus_abort)
    );

    // Bus-side model: answers each request two falling edges after seeing it
    initial forever begin
        @(negedge clk);
        if (bus_done) bus_done = 1'b0;
        else if (bus_req) begin
            if (lat == 1) begin
                lat = 0;
                bus_done = 1'b1;
                case (bus_op)
                    2'd0: begin
                        n_start++;
                        bus_fail = tb_fail;
                        if (!tb_fail) bus_active = 1'b1;
                    end
                    2'd1: if (!bus_rd) last_tx = bus_wdata;
                    default: begin
                        n_end++;
                        bus_active = 1'b0;
                    end
                endcase
            end else lat++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    // Vector: slv, wdata, cmd, fail, rx, stat, data, raw, starts, ends, tx
    typedef struct packed {
        logic [7:0] slv;
        logic [7:0] wd;
        logic [7:0] cmd;
        logic       fail;
        logic [7:0] rx;
        logic [7:0] stat;
        logic [7:0] data;
        logic       raw;
        logic [3:0] starts;
        logic [3:0] ends;
        logic [7:0] tx;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{8'hA0, 8'h5A, 8'h03, 1'b0, 8'h00, 8'h21, 8'h5A, 1'b1, 4'd1, 4'd0, 8'h5A},
        '{8'hA0, 8'h11, 8'h05, 1'b0, 8'h00, 8'h20, 8'h11, 1'b1, 4'd0, 4'd1, 8'h11},
        '{8'hA1, 8'h99, 8'h07, 1'b0, 8'hC3, 8'h20, 8'hC3, 1'b1, 4'd1, 4'd1, 8'h00},
        '{8'hA0, 8'h22, 8'h01, 1'b0, 8'h00, 8'h22, 8'h22, 1'b0, 4'd0, 4'd0, 8'h00},
        '{8'hA0, 8'h33, 8'h03, 1'b1, 8'h00, 8'h32, 8'h33, 1'b0, 4'd1, 4'd0, 8'h00},
        '{8'hA0, 8'h44, 8'h02, 1'b0, 8'h00, 8'h23, 8'h44, 1'b0, 4'd1, 4'd0, 8'h00},
        '{8'hA0, 8'h55, 8'h03, 1'b0, 8'h00, 8'h21, 8'h55, 1'b1, 4'd0, 4'd0, 8'h55},
        '{8'hA0, 8'h66, 8'h04, 1'b0, 8'h00, 8'h20, 8'h66, 1'b0, 4'd0, 4'd1, 8'h00}
    };

    // Watchdog
    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int s0, e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset values
        rd(3'd3, v); check("R9 period reset", v, 8'h01);
        rd(3'd0, v); check("R9 slave reset", v, 0);
        rd(3'd2, v); check("R9 data reset", v, 0);
        rd(3'd7, v); check("R9 config reset", v, 0);
        rd(3'd5, v); check("R9 raw reset", v, 0);
        rd(3'd1, v); check("R7 R9 status reset", v, 8'h20);

        // R2: command ignored with master disabled
        wr(3'd1, 8'h07); settle();
        check("R2 disabled no request", n_start + n_end, 0);
        rd(3'd1, v); check("R2 disabled status", v, 8'h20);

        // R1: register widths and config mask
        wr(3'd7, 8'hFF); rd(3'd7, v); check("R1 config mask", v, 8'h31);
        wr(3'd3, 8'hB7); rd(3'd3, v); check("R1 period store", v, 8'hB7);
        wr(3'd0, 8'hED); rd(3'd0, v); check("R1 slave store", v, 8'hED);
        wr(3'd7, 8'h10);
        wr(3'd4, 8'h01);

        // Vector table: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            wr(3'd5, 8'h01);
            wr(3'd0, VEC[i].slv);
            wr(3'd2, VEC[i].wd);
            tb_fail = VEC[i].fail;
            bus_rdata = VEC[i].rx;
            s0 = n_start; e0 = n_end;
            wr(3'd1, VEC[i].cmd);
            settle();
            rd(3'd1, v); check($sformatf("R4 R5 R7 vec%0d status", i), v, VEC[i].stat);
            rd(3'd2, v); check($sformatf("R5 vec%0d data", i), v, VEC[i].data);
            rd(3'd5, v); check($sformatf("R8 vec%0d raw", i), v, VEC[i].raw);
            check($sformatf("R8 vec%0d irq", i), irq, VEC[i].raw);
            check($sformatf("R3 vec%0d starts", i), n_start - s0, VEC[i].starts);
            check($sformatf("R6 vec%0d ends", i), n_end - e0, VEC[i].ends);
            if (VEC[i].raw && !VEC[i].slv[0])
                check($sformatf("R5 vec%0d sent byte", i), last_tx, VEC[i].tx);
        end
        tb_fail = 1'b0;

        // R8: write 0 keeps raw, mask gates irq and masked read, write 1 clears
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h07); settle();
        wr(3'd5, 8'h00); rd(3'd5, v); check("R8 write 0 keeps raw", v, 1);
        wr(3'd4, 8'h00);
        check("R8 irq masked off", irq, 0);
        rd(3'd6, v); check("R8 masked read off", v, 0);
        wr(3'd4, 8'h01);
        rd(3'd6, v); check("R8 masked read on", v, 1);
        wr(3'd5, 8'h01); rd(3'd5, v); check("R8 write 1 clears", v, 0);

        // R2: second command during a running sequence is ignored
        e0 = n_end;
        wr(3'd1, 8'h03);
        wr(3'd1, 8'h04);
        settle();
        check("R2 busy command ignored", n_end - e0, 0);
        rd(3'd1, v); check("R2 still busy", v, 8'h21);

        // R9: reset during a transfer releases the bus
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R9 abort during reset", bus_abort, 1);
        @(negedge clk);
        check("R9 abort drops", bus_abort, 0);
        rst_n = 1'b1;
        bus_active = 1'b0;
        rd(3'd1, v); check("R9 status after reset", v, 8'h20);
        rd(3'd3, v); check("R9 period after reset", v, 8'h01);
        rd(3'd7, v); check("R9 config after reset", v, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule